// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a 64-bit pointer and hands back the pointer with that tag placed in bits [59:56]. It has two modes. In random mode a 16-bit LFSR seed, held in a state word together with a start tag, is stepped four times. The four feedback bits form an offset, and that offset is walked through the tag space from the start tag. In add-tag mode the start tag is the one already in the pointer, and the offset comes in on its own input. In both modes, tags marked in an exclusion mask are skipped during the walk.

The walk tests one candidate tag per clock under a small state machine. A caller pulses `start` while the block is idle. `busy` stays high while the walk runs. `done` pulses for one cycle when `ptr_out` and `state_out` hold the result, and both outputs keep that value until the next accepted start. In random mode the state word is rewritten with the chosen tag and the advanced seed, so the next call continues the sequence. If the seed is zero while random generation is enabled, the constant 1 is used as the seed.

Top module: `alloc_tag_gen`

## Requirements
- R1: In random mode (`mode`=0) the exclusion mask is the bitwise OR of `op_excl` and `ctl_excl`; bit k set means tag k may not be chosen.
- R2: When the exclusion mask has all 16 bits set, the result tag is 0 and `done` rises one cycle after the accepted start.
- R3: Random mode steps the seed four times. Each step takes feedback = seed[5]^seed[3]^seed[2]^seed[0], shifts the seed right by one and puts the feedback into bit 15. Step one gives offset bit 0 and step four gives offset bit 3. `state_out` then holds the result tag in [3:0] and the advanced seed in [23:8], and all its other bits are zero.
- R4: With offset zero, the result is the start tag when that tag is allowed. Otherwise it is the first allowed tag found by counting upward modulo 16.
- R5: With offset N>0, the tag moves forward N times. Each move steps up modulo 16 at least once and carries on past excluded tags.
- R6: In add-tag mode (`mode`=1) the start tag is `ptr_in`[59:56], the offset is `ofs_in`, only `ctl_excl` excludes tags (`op_excl` has no effect), and `state_out` equals `state_in`.
- R7: In random mode, a seed field of zero with `ctl_rand_en`=1 is replaced by seed 1 before stepping. With `ctl_rand_en`=0 a zero seed stays zero, giving offset 0.
- R8: `ptr_out` equals the accepted `ptr_in` in every bit except [59:56], which carry the result tag.
- R9: One candidate is tested per clock, so `done` comes 1 + (candidates tested) cycles after the accepted start, never later than 1+16*(N+1). `done` is a single-cycle pulse, and `busy` is high during the walk and low in the cycle where `done` is high.
- R10: A `start` while `busy` is high is ignored, and `ptr_out`/`state_out` hold their values until the next accepted start completes.
- R11: After synchronous reset `done` and `busy` are 0 and `ptr_out` and `state_out` are all zeros. A reset during a walk abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 1 | 0 = random tag, 1 = add offset to pointer tag |
| ptr_in | input | 64 | Pointer to retag |
| op_excl | input | 16 | Operand exclusion mask (random mode only) |
| ctl_excl | input | 16 | Control exclusion mask (both modes) |
| ctl_rand_en | input | 1 | Random-generation enable; selects zero-seed substitution |
| ofs_in | input | 4 | Tag offset for add-tag mode |
| state_in | input | 32 | Start tag [3:0] and seed [23:8] |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ptr_out | output | 64 | Pointer with the new tag |
| state_out | output | 32 | Updated state word |

## Verification
A wrong LFSR tap or feedback order shows up at once in `state_out` bits [23:8] and, through the offset, in the tag, on the same `done` pulse as the request. A walker that loses its remaining-move count or its candidate register either lands on the wrong tag or makes `done` arrive early or late. The bench counts that latency exactly, so an extra or a missing step shows up as a cycle difference even when the final tag happens to match. A latch enable that ignores `busy` corrupts the result of the walk already in flight. The bench catches this with a second start issued in the middle of a long walk.

// File: rtl/atg_pkg.sv
package atg_pkg;
  typedef enum logic {
    MODE_RAND = 1'b0,
    MODE_ADD  = 1'b1
  } atg_mode_e;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_WALK = 1'b1
  } walk_state_e;
endpackage

// File: rtl/atg_lfsr.sv
module atg_lfsr #(
  parameter int SEED_W   = 16,
  parameter int STEPS    = 4,
  parameter int TAPS     = 'h2D,
  parameter int FALLBACK = 1
) (
  input  logic              rand_en,
  input  logic [SEED_W-1:0] seed_in,
  output logic [STEPS-1:0]  ofs_out,
  output logic [SEED_W-1:0] seed_out
);
  localparam logic [SEED_W-1:0] TAP_MASK = SEED_W'(TAPS);
  localparam logic [SEED_W-1:0] SUB_SEED = SEED_W'(FALLBACK);

  logic [SEED_W-1:0] seed_eff;

  // R7: zero seed replaced only while random generation is enabled
  always_comb begin
    seed_eff = seed_in;
    if (rand_en && (seed_in == '0)) seed_eff = SUB_SEED;
  end

  // R3: shift right, feedback into the top bit; step k yields offset bit k
  always_comb begin
    logic [SEED_W-1:0] s;
    logic              fb;
    s = seed_eff;
    ofs_out = '0;
    for (int k = 0; k < STEPS; k++) begin
      fb = ^(s & TAP_MASK);
      ofs_out[k] = fb;
      s = {fb, s[SEED_W-1:1]};
    end
    seed_out = s;
  end

  // R3: a live seed never collapses to zero through the stepping
  always_comb begin
    a_r3_seed_alive: assert (seed_eff == '0 || seed_out != '0);
  end
endmodule

// File: rtl/atg_walker.sv
module atg_walker
  import atg_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [TAG_W-1:0]      tag0,
  input  logic [TAG_W-1:0]      ofs,
  input  logic [(1<<TAG_W)-1:0] mask,
  output logic                  busy,
  output logic                  done,
  output logic [TAG_W-1:0]      res
);
  localparam int NTAG = 1 << TAG_W;
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  walk_state_e      st;
  logic [NTAG-1:0]  mask_q;
  logic [TAG_W-1:0] cand;
  logic [TAG_W-1:0] left;
  logic             hit;

  assign hit  = !mask_q[cand];
  assign busy = (st == WK_WALK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WK_IDLE;
      mask_q <= '0;
      cand   <= '0;
      left   <= '0;
      done   <= 1'b0;
      res    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        WK_IDLE: begin
          if (go) begin
            mask_q <= mask;
            if (&mask) begin
              // R2: nothing allowed, answer zero without walking
              res  <= '0;
              done <= 1'b1;
            end else begin
              // R4 tests the start tag itself; R5 begins one above it
              cand <= (ofs == '0) ? tag0 : tag0 + ONE;
              left <= (ofs == '0) ? ONE : ofs;
              st   <= WK_WALK;
            end
          end
        end
        WK_WALK: begin
          if (hit && left == ONE) begin
            res  <= cand;
            done <= 1'b1;
            st   <= WK_IDLE;
          end else begin
            if (hit) left <= left - ONE;
            cand <= cand + ONE;
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  // checker state: length of the current run of excluded candidates
  logic [TAG_W:0] miss_run;
  always_ff @(posedge clk) begin
    if (rst || st != WK_WALK) miss_run <= '0;
    else if (hit)             miss_run <= '0;
    else                      miss_run <= miss_run + 1'b1;
  end

  // R5: a run of excluded tags is shorter than the tag space
  a_r5_skip_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> miss_run < (TAG_W+1)'(NTAG));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy has dropped by the cycle done is seen
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: a walked result is never an excluded tag
  a_r4_result_allowed: assert property (@(posedge clk) disable iff (rst)
    (done && !(&mask_q)) |-> !mask_q[res]);
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen
  import atg_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int TAG_W    = 4,
  parameter int TAG_LSB  = 56,
  parameter int SEED_W   = 16,
  parameter int SEED_LSB = 8,
  parameter int ST_W     = 32,
  parameter int TAPS     = 'h2D,
  parameter int FALLBACK = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  mode,
  input  logic [PTR_W-1:0]      ptr_in,
  input  logic [(1<<TAG_W)-1:0] op_excl,
  input  logic [(1<<TAG_W)-1:0] ctl_excl,
  input  logic                  ctl_rand_en,
  input  logic [TAG_W-1:0]      ofs_in,
  input  logic [ST_W-1:0]       state_in,
  output logic                  busy,
  output logic                  done,
  output logic [PTR_W-1:0]      ptr_out,
  output logic [ST_W-1:0]       state_out
);
  localparam int NTAG = 1 << TAG_W;

  logic              accept;
  logic [TAG_W-1:0]  rnd_ofs;
  logic [SEED_W-1:0] seed_nx;
  logic [TAG_W-1:0]  sel_tag;
  logic [TAG_W-1:0]  sel_ofs;
  logic [NTAG-1:0]   sel_mask;
  logic [TAG_W-1:0]  res;

  atg_mode_e         mode_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [ST_W-1:0]   state_q;
  logic [SEED_W-1:0] seed_q;

  assign accept = start && !busy;  // R10

  atg_lfsr #(
    .SEED_W  (SEED_W),
    .STEPS   (TAG_W),
    .TAPS    (TAPS),
    .FALLBACK(FALLBACK)
  ) u_lfsr (
    .rand_en (ctl_rand_en),
    .seed_in (state_in[SEED_LSB +: SEED_W]),
    .ofs_out (rnd_ofs),
    .seed_out(seed_nx)
  );

  // R1 / R6: operand selection per mode
  always_comb begin
    if (atg_mode_e'(mode) == MODE_ADD) begin
      sel_tag  = ptr_in[TAG_LSB +: TAG_W];
      sel_ofs  = ofs_in;
      sel_mask = ctl_excl;
    end else begin
      sel_tag  = state_in[TAG_W-1:0];
      sel_ofs  = rnd_ofs;
      sel_mask = op_excl | ctl_excl;
    end
  end

  atg_walker #(
    .TAG_W(TAG_W)
  ) u_walk (
    .clk (clk),
    .rst (rst),
    .go  (accept),
    .tag0(sel_tag),
    .ofs (sel_ofs),
    .mask(sel_mask),
    .busy(busy),
    .done(done),
    .res (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_RAND;
      ptr_q   <= '0;
      state_q <= '0;
      seed_q  <= '0;
    end else if (accept) begin
      mode_q  <= atg_mode_e'(mode);
      ptr_q   <= ptr_in;
      state_q <= state_in;
      seed_q  <= seed_nx;
    end
  end

  // R8: only the tag field is replaced
  always_comb begin
    ptr_out = ptr_q;
    ptr_out[TAG_LSB +: TAG_W] = res;
  end

  // R3 / R6: rewritten state in random mode, untouched in add mode
  always_comb begin
    if (mode_q == MODE_ADD) begin
      state_out = state_q;
    end else begin
      state_out = '0;
      state_out[SEED_LSB +: SEED_W] = seed_q;
      state_out[TAG_W-1:0] = res;
    end
  end

  // R2: a full mask answers zero on the next edge
  a_r2_full_fast: assert property (@(posedge clk) disable iff (rst)
    (accept && (&sel_mask)) |=> (done && ptr_out[TAG_LSB +: TAG_W] == '0));

  // R10: latched request stays put while a walk is running
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ptr_q) && $stable(seed_q)));
endmodule

// File: tb/alloc_tag_gen_tb.sv
module alloc_tag_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [63:0] ptr_in = '0;
  logic [15:0] op_excl = '0;
  logic [15:0] ctl_excl = '0;
  logic        ctl_rand_en = 1'b0;
  logic [3:0]  ofs_in = '0;
  logic [31:0] state_in = '0;
  logic        busy, done;
  logic [63:0] ptr_out;
  logic [31:0] state_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  alloc_tag_gen u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ptr_in(ptr_in),
    .op_excl(op_excl), .ctl_excl(ctl_excl), .ctl_rand_en(ctl_rand_en),
    .ofs_in(ofs_in), .state_in(state_in), .busy(busy), .done(done),
    .ptr_out(ptr_out), .state_out(state_out)
  );

  typedef struct packed {
    logic        md;
    logic [3:0]  ptag;
    logic [3:0]  ofs;
    logic [15:0] opm;
    logic [15:0] ctm;
    logic        ren;
    logic [31:0] st;
    logic [3:0]  etag;
    logic [31:0] est;
    logic [7:0]  elat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h2, 4'h0, 16'h0000, 16'h0000, 1'b1, 32'hFF0001A3, 4'h4, 32'h00100004, 8'd2},
    '{1'b0, 4'h0, 4'h0, 16'h0020, 16'h0000, 1'b1, 32'h00FFFF05, 4'h6, 32'h000FFF06, 8'd3},
    '{1'b0, 4'h0, 4'h0, 16'h0000, 16'h8001, 1'b1, 32'h00002D0E, 4'h2, 32'h00200202, 8'd5},
    '{1'b0, 4'h0, 4'h0, 16'h00F0, 16'h0300, 1'b1, 32'h00000900, 4'h0, 32'h00A00000, 8'd17},
    '{1'b0, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b1, 32'h00000007, 4'h8, 32'h00100008, 8'd2},
    '{1'b0, 4'h0, 4'h0, 16'h0000, 16'h0000, 1'b0, 32'h00000009, 4'h9, 32'h00000009, 8'd2},
    '{1'b0, 4'h0, 4'h0, 16'hFF00, 16'h00FF, 1'b1, 32'h00000104, 4'h0, 32'h00100000, 8'd1},
    '{1'b1, 4'h6, 4'h0, 16'h0000, 16'h0000, 1'b0, 32'h12345678, 4'h6, 32'h12345678, 8'd2},
    '{1'b1, 4'h6, 4'h3, 16'hFFFF, 16'h0080, 1'b0, 32'h0BADF00D, 4'hA, 32'h0BADF00D, 8'd5},
    '{1'b1, 4'hF, 4'h0, 16'h0000, 16'h8003, 1'b0, 32'h00000000, 4'h2, 32'h00000000, 8'd5},
    '{1'b1, 4'h9, 4'h5, 16'h0000, 16'hFFFF, 1'b1, 32'hCAFE0001, 4'h0, 32'hCAFE0001, 8'd1}
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R1";
      4: return "R7";
      5: return "R7";
      6: return "R2";
      7: return "R6";
      8: return "R6";
      9: return "R4";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [63:0] mk_ptr(int i, logic [3:0] t);
    logic [63:0] p;
    p = 64'hA5C3_1E7B_4D29_6F80 ^ {32'(i * 32'h01010101), 32'(i * 32'h10203040)};
    p[59:56] = t;
    return p;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // launch one request and return the cycle count until done is seen
  task automatic launch(input vec_t v, input logic [63:0] p, output int lat);
    @(negedge clk);
    mode = v.md; ptr_in = p; op_excl = v.opm; ctl_excl = v.ctm;
    ctl_rand_en = v.ren; ofs_in = v.ofs; state_in = v.st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 80) begin
      @(negedge clk);
      lat++;
    end
  endtask

  always begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] p, ep, hold_p;
    logic [31:0] hold_s;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11", "done after reset", 64'(done), 64'd0);
    check("R11", "busy after reset", 64'(busy), 64'd0);
    check("R11", "ptr_out after reset", ptr_out, 64'd0);
    check("R11", "state_out after reset", 64'(state_out), 64'd0);

    for (int i = 0; i < NV; i++) begin
      p = mk_ptr(i, TBL[i].ptag);
      launch(TBL[i], p, lat);
      ep = p;
      ep[59:56] = TBL[i].etag;
      check(req_of(i), $sformatf("tag row %0d", i), 64'(ptr_out[59:56]), 64'(TBL[i].etag));
      check("R8", $sformatf("pointer row %0d", i), ptr_out, ep);
      check(req_of(i), $sformatf("state row %0d", i), 64'(state_out), 64'(TBL[i].est));
      check("R9", $sformatf("latency row %0d", i), 64'(lat), 64'(TBL[i].elat));
      check("R9", $sformatf("busy at done row %0d", i), 64'(busy), 64'd0);
      hold_p = ptr_out;
      hold_s = state_out;
      @(negedge clk);
      check("R9", $sformatf("done pulse row %0d", i), 64'(done), 64'd0);
      check("R10", $sformatf("hold ptr row %0d", i), ptr_out, hold_p);
      check("R10", $sformatf("hold state row %0d", i), 64'(state_out), 64'(hold_s));
    end

    // R10: start during a long walk is ignored
    p = mk_ptr(3, 4'h0);
    @(negedge clk);
    mode = TBL[3].md; ptr_in = p; op_excl = TBL[3].opm; ctl_excl = TBL[3].ctm;
    ctl_rand_en = TBL[3].ren; ofs_in = TBL[3].ofs; state_in = TBL[3].st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "busy mid walk", 64'(busy), 64'd1);
    mode = 1'b1; ptr_in = 64'h0; ctl_excl = 16'h0; ofs_in = 4'h0; state_in = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 80) begin
      @(negedge clk);
      lat++;
    end
    check("R10", "latency with ignored start", 64'(lat), 64'd17);
    check("R10", "ptr with ignored start", ptr_out, p);
    check("R10", "state with ignored start", 64'(state_out), 64'h00A00000);
    @(negedge clk);
    check("R10", "no second done", 64'(done), 64'd0);
    check("R10", "no second walk", 64'(busy), 64'd0);

    // R11: reset abandons a walk in progress
    @(negedge clk);
    mode = TBL[3].md; ptr_in = p; op_excl = TBL[3].opm; ctl_excl = TBL[3].ctm;
    ctl_rand_en = TBL[3].ren; ofs_in = TBL[3].ofs; state_in = TBL[3].st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "busy after mid reset", 64'(busy), 64'd0);
    check("R11", "ptr after mid reset", ptr_out, 64'd0);
    repeat (20) @(negedge clk);
    check("R11", "no done after abandon", 64'(done), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule